// File: doc/BRIEF.md
# Transmit Descriptor Status Write-Back Sequencer

This block walks a stream of legacy-format transmit descriptors one at a time and decides what each one needs. A descriptor arrives as a buffer address, a byte length and an 8-bit command byte over a valid/ready handshake. If the descriptor points at real data, the block issues one fetch request to the DMA engine. It then waits for the engine's fetch-complete pulse. If the descriptor asks for status reporting, the block issues one write-back request that sets the done bit in that descriptor's status word. Every descriptor that is handled normally ends with a one-cycle completion event to the interrupt timer. That event carries the descriptor's report and delay bits.

A descriptor with a null buffer address or a zero length moves no data. It still receives its done-bit write-back when reporting is requested. A descriptor marked as the extended format is not legal here: it is flagged with an error pulse and dropped without any fetch or write-back. Every accepted descriptor, dropped or not, takes the next value of a wrapping sequence tag. The write-back request carries that tag so the status is written to the right slot.

Back-pressure rules: the descriptor input is taken only while `desc_ready` is high, and `desc_ready` stays low from acceptance until that descriptor has fully finished. The fetch request and the write-back request each hold their valid and payload steady until the matching ready is seen high at a clock edge. The fetch-complete input is a plain one-cycle pulse with no ready. It is ignored when no fetch is outstanding.

Top module: `tx_desc_wb`

## Requirements
- R1: After reset, `desc_ready` is 1 and `fetch_valid`, `wb_valid`, `done_evt` and `desc_err` are all 0.
- R2: Only three command bits are used: bit 7 is delay-enable, bit 5 is the extended-format flag, bit 3 is report-status. Bits 6, 4, 2, 1 and 0 have no effect on any output.
- R3: A descriptor with the extended flag clear, a nonzero address and a nonzero length produces exactly one fetch request carrying that address and length.
- R4: A descriptor with address 0 or length 0 produces no fetch request.
- R5: With report-status set, exactly one write-back request is made, carrying the descriptor's tag. It is raised in the cycle after the fetch-complete pulse, or in the first cycle after acceptance when there is no data.
- R6: With report-status clear, no write-back request is made.
- R7: A descriptor with the extended flag set produces one `desc_err` pulse and no fetch, no write-back and no completion event.
- R8: Every descriptor without the extended flag produces exactly one `done_evt` pulse, after its write-back is accepted or its fetch completes. The pulse carries `evt_rs` and `evt_ide` equal to its report-status and delay-enable bits.
- R9: `desc_ready` is 0 from the cycle after acceptance until the completion or error pulse has been given. At most one of `fetch_valid`, `wb_valid`, `done_evt` and `desc_err` is high in any cycle.
- R10: The tag starts at 0 after reset, increases by one for each accepted descriptor including dropped ones, and wraps at 2^TAG_W.
- R11: A fetch or write-back request that is not accepted keeps its valid and payload unchanged in the next cycle.
- R12: The delay-enable bit never holds back the write-back request. Its timing is the same whether bit 7 is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block can take a descriptor |
| desc_addr | input | ADDR_W | Buffer address of the descriptor |
| desc_len | input | LEN_W | Buffer length in bytes |
| desc_cmd | input | 8 | Command byte |
| fetch_valid | output | 1 | Fetch request to the DMA engine |
| fetch_ready | input | 1 | DMA engine takes the fetch request |
| fetch_addr | output | ADDR_W | Address to fetch |
| fetch_len | output | LEN_W | Length to fetch |
| fetch_done | input | 1 | One-cycle pulse: outstanding fetch finished |
| wb_valid | output | 1 | Request to write the done bit |
| wb_ready | input | 1 | Write-back request taken |
| wb_tag | output | TAG_W | Sequence tag of the descriptor being written back |
| done_evt | output | 1 | One-cycle completion event to the interrupt timer |
| evt_rs | output | 1 | Report-status bit of the completed descriptor |
| evt_ide | output | 1 | Delay-enable bit of the completed descriptor |
| desc_err | output | 1 | One-cycle pulse: extended-format descriptor dropped |

## Verification
A control state that is stuck or skipped shows up at the ports within a cycle or two. `desc_ready` stays low with no request pending, or a request appears that the command byte did not ask for. A wrong captured command or tag shows up the first time that descriptor reaches its write-back or completion event: the tag, `evt_rs` or `evt_ide` disagrees with what was sent. Any extra delay on the write-back path is caught by the bench, which measures the exact cycle between the fetch-complete pulse and `wb_valid` for every descriptor.

// File: rtl/tx_wb_pkg.sv
package tx_wb_pkg;

  // command byte bit positions this block decodes
  localparam int BIT_DLY = 7;
  localparam int BIT_EXT = 5;
  localparam int BIT_RPT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WB,
    ST_FIN,
    ST_ERR
  } wb_state_t;

  typedef struct packed {
    logic dly;
    logic ext;
    logic rpt;
    logic nodata;
  } cmd_info_t;

endpackage

// File: rtl/txd_decode.sv
module txd_decode
  import tx_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [7:0]        cmd,
  output cmd_info_t         info
);

  always_comb begin
    info.dly    = cmd[BIT_DLY];
    info.ext    = cmd[BIT_EXT];
    info.rpt    = cmd[BIT_RPT];
    info.nodata = (addr == '0) || (len == '0);
  end

endmodule

// File: rtl/txd_seq.sv
module txd_seq #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [TAG_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assert_tag_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import tx_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  input  cmd_info_t         info,
  input  logic [TAG_W-1:0]  tag_in,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [LEN_W-1:0]  fetch_len,
  input  logic              fetch_done,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [TAG_W-1:0]  wb_tag,
  output logic              done_evt,
  output logic              evt_rs,
  output logic              evt_ide,
  output logic              desc_err
);

  wb_state_t         st, st_nx;
  logic              cur_rpt, cur_dly;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_len;
  logic [TAG_W-1:0]  cur_tag;
  logic              take;

  assign take = desc_valid && desc_ready;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:
        if (desc_valid) begin
          if (info.ext)         st_nx = ST_ERR;
          else if (!info.nodata) st_nx = ST_REQ;
          else if (info.rpt)    st_nx = ST_WB;
          else                  st_nx = ST_FIN;
        end
      ST_REQ:  if (fetch_ready) st_nx = ST_WAIT;
      ST_WAIT: if (fetch_done)  st_nx = cur_rpt ? ST_WB : ST_FIN;
      ST_WB:   if (wb_ready)    st_nx = ST_FIN;
      ST_FIN:  st_nx = ST_IDLE;
      ST_ERR:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_rpt  <= 1'b0;
      cur_dly  <= 1'b0;
      cur_addr <= '0;
      cur_len  <= '0;
      cur_tag  <= '0;
    end else begin
      st <= st_nx;
      if (take) begin
        cur_rpt  <= info.rpt;
        cur_dly  <= info.dly;
        cur_addr <= desc_addr;
        cur_len  <= desc_len;
        cur_tag  <= tag_in;
      end
    end
  end

  assign desc_ready  = (st == ST_IDLE);
  assign fetch_valid = (st == ST_REQ);
  assign fetch_addr  = cur_addr;
  assign fetch_len   = cur_len;
  assign wb_valid    = (st == ST_WB);
  assign wb_tag      = cur_tag;
  assign done_evt    = (st == ST_FIN);
  assign evt_rs      = done_evt && cur_rpt;
  assign evt_ide     = done_evt && cur_dly;
  assign desc_err    = (st == ST_ERR);

  assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr) && $stable(fetch_len));

  assert_wb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_tag));

  assert_one_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_valid, wb_valid, done_evt, desc_err}));

  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !desc_ready);

  assert_wb_needs_rs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> cur_rpt);

  assert_evt_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> desc_ready && !done_evt);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> $past(desc_ready) && !done_evt);

endmodule

// File: rtl/tx_desc_wb.sv
module tx_desc_wb
  import tx_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [7:0]        desc_cmd,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [LEN_W-1:0]  fetch_len,
  input  logic              fetch_done,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [TAG_W-1:0]  wb_tag,
  output logic              done_evt,
  output logic              evt_rs,
  output logic              evt_ide,
  output logic              desc_err
);

  cmd_info_t        info;
  logic [TAG_W-1:0] tag_now;

  txd_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .addr (desc_addr),
    .len  (desc_len),
    .cmd  (desc_cmd),
    .info (info)
  );

  txd_seq #(.TAG_W(TAG_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (desc_valid && desc_ready),
    .cnt   (tag_now)
  );

  txd_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .desc_addr   (desc_addr),
    .desc_len    (desc_len),
    .info        (info),
    .tag_in      (tag_now),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_addr  (fetch_addr),
    .fetch_len   (fetch_len),
    .fetch_done  (fetch_done),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_tag      (wb_tag),
    .done_evt    (done_evt),
    .evt_rs      (evt_rs),
    .evt_ide     (evt_ide),
    .desc_err    (desc_err)
  );

endmodule

// File: tb/tx_desc_wb_test.sv
module tx_desc_wb_test;

  localparam int AW = 32;
  localparam int LW = 16;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          desc_valid = 1'b0;
  logic          desc_ready;
  logic [AW-1:0] desc_addr = '0;
  logic [LW-1:0] desc_len = '0;
  logic [7:0]    desc_cmd = '0;
  logic          fetch_valid;
  logic          fetch_ready = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic [LW-1:0] fetch_len;
  logic          fetch_done = 1'b0;
  logic          wb_valid;
  logic          wb_ready = 1'b0;
  logic [TW-1:0] wb_tag;
  logic          done_evt, evt_rs, evt_ide, desc_err;

  int errors = 0;
  int checks = 0;
  logic [TW-1:0] exp_tag = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  tx_desc_wb #(.ADDR_W(AW), .LEN_W(LW), .TAG_W(TW)) uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit f_ext(input logic [7:0] c); return c[5]; endfunction
  function automatic bit f_rs(input logic [7:0] c);  return c[3]; endfunction
  function automatic bit f_ide(input logic [7:0] c); return c[7]; endfunction
  function automatic bit f_nodata(input logic [AW-1:0] a, input logic [LW-1:0] l);
    return (a == 0) || (l == 0);
  endfunction

  task automatic run_desc(input logic [AW-1:0] a, input logic [LW-1:0] l,
                          input logic [7:0] c);
    bit ext, rs, ide, nod;
    int n_fetch, n_wb, n_evt, n_err, ref_i, wb_first, cd;
    bit pend, ended, busy_bad, hold_bad;
    logic [AW-1:0] pa; logic [LW-1:0] pl; logic pfv, pwv; logic [TW-1:0] pt;
    ext = f_ext(c); rs = f_rs(c); ide = f_ide(c); nod = f_nodata(a, l);
    n_fetch = 0; n_wb = 0; n_evt = 0; n_err = 0; wb_first = -1;
    ref_i = nod ? -1 : -100; pend = 0; cd = 0; ended = 0;
    busy_bad = 0; hold_bad = 0; pfv = 0; pwv = 0; pa = '0; pl = '0; pt = '0;
    // offer at a negedge
    desc_valid = 1'b1; desc_addr = a; desc_len = l; desc_cmd = c;
    check(desc_ready === 1'b1, "R9", "ready before offer", desc_ready, 1);
    @(posedge clk); @(negedge clk);
    desc_valid = 1'b0; desc_cmd = $urandom; desc_addr = $urandom; desc_len = $urandom;
    for (int i = 0; i < 120 && !ended; i++) begin
      fetch_done = 1'b0;
      if (pfv && fetch_valid && (fetch_addr !== pa || fetch_len !== pl)) hold_bad = 1;
      if (pwv && wb_valid && wb_tag !== pt) hold_bad = 1;
      if (pfv && !fetch_valid) hold_bad = 1;
      if (pwv && !wb_valid) hold_bad = 1;
      if (pend) begin
        if (cd == 0) begin fetch_done = 1'b1; ref_i = i; pend = 0; end
        else cd--;
      end
      fetch_ready = ($urandom % 2) == 0;
      wb_ready    = ($urandom % 2) == 0;
      if (fetch_valid) begin
        if (fetch_addr !== a || fetch_len !== l) hold_bad = 1;
        if (fetch_ready) begin n_fetch++; pend = 1; cd = $urandom % 4; end
      end
      if (wb_valid) begin
        if (wb_first < 0) wb_first = i;
        check(wb_tag === exp_tag, "R5", "write-back tag", wb_tag, exp_tag);
        if (wb_ready) n_wb++;
      end
      pfv = fetch_valid && !fetch_ready; pa = fetch_addr; pl = fetch_len;
      pwv = wb_valid && !wb_ready; pt = wb_tag;
      if (done_evt) begin
        n_evt++; ended = 1;
        check(evt_rs === rs && evt_ide === ide, "R8", "event rs/ide bits",
              {evt_rs, evt_ide}, {rs, ide});
      end
      if (desc_err) begin n_err++; ended = 1; end
      if (!ended && desc_ready !== 1'b0) busy_bad = 1;
      @(posedge clk); @(negedge clk);
    end
    fetch_done = 1'b0; fetch_ready = 1'b0; wb_ready = 1'b0;
    check(!busy_bad, "R9", "ready low while busy", busy_bad, 0);
    check(!hold_bad, "R11", "request hold under back-pressure", hold_bad, 0);
    check(desc_ready === 1'b1 && done_evt === 1'b0, "R9", "idle after finish",
          desc_ready, 1);
    if (ext) begin
      check(n_err == 1 && n_evt == 0, "R7", "error pulse only", n_err, 1);
      check(n_fetch == 0 && n_wb == 0, "R7", "no fetch/write-back",
            n_fetch + n_wb, 0);
    end else begin
      check(n_err == 0 && n_evt == 1, "R8", "one completion event", n_evt, 1);
      if (nod) check(n_fetch == 0, "R4", "no fetch for null", n_fetch, 0);
      else     check(n_fetch == 1, "R3", "one fetch", n_fetch, 1);
      if (rs) begin
        check(n_wb == 1, "R5", "one write-back", n_wb, 1);
        check(wb_first == ref_i + 1, "R12", "write-back latency (ide ignored)",
              wb_first, ref_i + 1);
      end else begin
        check(n_wb == 0 && wb_first < 0, "R6", "no write-back", n_wb, 0);
      end
    end
    exp_tag = exp_tag + 1'b1; // R10 tag advances per accepted descriptor
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(desc_ready === 1 && fetch_valid === 0 && wb_valid === 0 &&
          done_evt === 0 && desc_err === 0, "R1", "outputs in reset",
          {desc_ready, fetch_valid, wb_valid, done_evt, desc_err}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(desc_ready === 1 && fetch_valid === 0 && wb_valid === 0, "R1",
          "outputs after reset", {desc_ready, fetch_valid, wb_valid}, 3'b100);
    // directed corners
    run_desc(32'h1000, 16'd64, 8'h08);   // R3 R5: data + report
    run_desc(32'h1000, 16'd64, 8'h88);   // R12: same with delay bit
    run_desc(32'h0, 16'd64, 8'h08);      // R4: null address, reported
    run_desc(32'h2000, 16'd0, 8'h88);    // R4: zero length, reported
    run_desc(32'h0, 16'd0, 8'h00);       // R6: null, unreported
    run_desc(32'h3000, 16'd9, 8'h57);    // R2: unused bits, report clear
    run_desc(32'h3000, 16'd9, 8'h28);    // R7: extended flag
    run_desc(32'h3000, 16'd9, 8'h08 | 8'h47); // R2: unused bits set, report on
    // random, enough to wrap the tag (R10)
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a; logic [LW-1:0] l; logic [7:0] c;
      a = (($urandom % 5) == 0) ? '0 : $urandom;
      l = (($urandom % 5) == 0) ? '0 : LW'($urandom);
      c = $urandom;
      if (($urandom % 4) != 0) c[5] = 1'b0;
      run_desc(a, l, c);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule